// File: doc/BRIEF.md
# UART FIFO Controller with Selectable 16/64 Depth

This block holds the receive and transmit byte queues of a 16550-style serial port, together with the control register logic that configures them. Software writes the FIFO control register to turn the queues on or off, to empty either queue, to select a deeper 64-entry mode, and to choose the receive fill level at which a data-ready condition is raised. Three queue depths are possible. With the queues disabled, each side behaves as a single-byte holding register. In standard mode each queue holds 16 bytes. In extended mode each queue holds 64 bytes.

A small register port exposes three locations. Address 2 is the control register when written and the interrupt identification register when read. Address 3 is the line control register, whose bit 7 is the divisor-latch access bit. Every data path uses valid/ready handshakes. On the write side of each queue, `*_in_ready` is high whenever the queue has room. The upstream serial shifter cannot stall, so a byte that is offered while ready is low is discarded and the overrun flag of that queue is set. On the read side, `*_out_valid` is high while the queue holds data, and a byte leaves the queue on a cycle where valid and ready are both high. Pulling ready while valid is low has no effect on the queue.

Top module: `uart_fifo_ctl`

## Requirements
- R1: After reset the queues are disabled, a read at address 2 returns 8'h01, both queues are empty with `rx_in_ready` high, and both overrun flags are low.
- R2: A write to address 2 updates the control state only while bit 7 of the line control register (address 3) is 0. While that bit is 1, the write is ignored.
- R3: Control write bit 0 enables the queues and bit 5 selects extended mode. Extended mode takes effect only if bit 0 is also set in the same write. Read bits [7:5] of address 2 are 3'b000 when disabled, 3'b110 in standard mode and 3'b111 in extended mode.
- R4: A queue accepts at most 1 byte when disabled, 16 bytes in standard mode and 64 bytes in extended mode. `*_in_ready` is low exactly when that count is reached.
- R5: In standard mode, control write bits [7:6] select a receive trigger of 1, 4, 8 or 14 bytes for codes 0, 1, 2 and 3.
- R6: In extended mode, codes 0, 1, 2 and 3 select a receive trigger of 1, 16, 32 or 56 bytes.
- R7: `rx_data_avail` is high exactly while the receive level is at or above the trigger. Read bits [3:0] of address 2 are 4'b0100 while it is high and 4'b0001 otherwise.
- R8: A control write that changes either the enable state or the extended-mode state empties both queues. A write that keeps both states unchanged leaves the contents in place.
- R9: Control write bit 1 empties the receive queue and bit 2 empties the transmit queue. Both act only during the write that carries them.
- R10: A byte offered to a full queue is dropped and sets that queue's overrun flag. The flag stays high until that queue is emptied by a control write.
- R11: A read handshake on an empty queue leaves the level unchanged, and `*_out_data` keeps showing the last byte that was removed.
- R12: Bytes leave each queue in arrival order, including on cycles where a byte enters and a byte leaves at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr |
| rx_in_valid | input | 1 | Received byte offered by the shifter |
| rx_in_ready | output | 1 | Receive queue has room |
| rx_in_data | input | 8 | Received byte |
| rx_out_valid | output | 1 | Receive queue holds data |
| rx_out_ready | input | 1 | Reader takes a received byte |
| rx_out_data | output | 8 | Oldest received byte, or last removed byte when empty |
| tx_in_valid | input | 1 | Byte offered for transmission |
| tx_in_ready | output | 1 | Transmit queue has room |
| tx_in_data | input | 8 | Byte to transmit |
| tx_out_valid | output | 1 | Transmit queue holds data |
| tx_out_ready | input | 1 | Shifter takes a byte |
| tx_out_data | output | 8 | Oldest byte to transmit |
| rx_level | output | 7 | Receive queue fill count |
| rx_data_avail | output | 1 | Receive level at or above trigger |
| rx_overrun | output | 1 | Sticky receive overrun flag |
| tx_overrun | output | 1 | Sticky transmit overrun flag |

## Verification
The hardest states to reach are the upper extended-mode triggers and the 64-entry full boundary. Reaching them means enabling extended mode in a single control write and then filling the receive queue with long runs of pushes. Each run starts from a queue emptied by a receive-flush write, and the run length is set by the trigger under test. A scoreboard queue, flushed whenever the bench expects the design to empty the queue, follows every accepted byte. This exposes reordering and lost entries after pointer wrap and after simultaneous enter/leave cycles.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;

  localparam int DATA_W      = 8;
  localparam int MAX_DEPTH   = 64;
  localparam int SMALL_DEPTH = 16;
  localparam int LVL_W       = $clog2(MAX_DEPTH + 1);

  typedef enum logic [1:0] {
    MODE_OFF = 2'd0,
    MODE_STD = 2'd1,
    MODE_EXT = 2'd2
  } fifo_mode_e;

  typedef logic [LVL_W-1:0] level_t;

  // Receive trigger lookup for each depth mode.
  function automatic level_t trig_of(fifo_mode_e m, logic [1:0] code);
    level_t t;
    t = level_t'(1);
    if (m == MODE_EXT) begin
      case (code)
        2'd1:    t = level_t'(16);
        2'd2:    t = level_t'(32);
        2'd3:    t = level_t'(56);
        default: t = level_t'(1);
      endcase
    end else if (m == MODE_STD) begin
      case (code)
        2'd1:    t = level_t'(4);
        2'd2:    t = level_t'(8);
        2'd3:    t = level_t'(14);
        default: t = level_t'(1);
      endcase
    end
    return t;
  endfunction

endpackage

// File: rtl/fifo_core.sv
module fifo_core
  import uart_fifo_pkg::*;
#(
  parameter int DW     = DATA_W,
  parameter int MAXD   = MAX_DEPTH,
  parameter int SMALLD = SMALL_DEPTH
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        clr,
  input  fifo_mode_e                  mode,
  input  logic                        in_valid,
  output logic                        in_ready,
  input  logic [DW-1:0]               in_data,
  output logic                        out_valid,
  input  logic                        out_ready,
  output logic [DW-1:0]               out_data,
  output logic [$clog2(MAXD+1)-1:0]   level,
  output logic                        overrun
);
  localparam int AW = $clog2(MAXD);
  localparam int CW = $clog2(MAXD + 1);

  logic [DW-1:0] mem [MAXD];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt, cur_depth;
  logic [DW-1:0] last_q;
  logic          full, empty, do_push, do_pop;

  always_comb begin
    case (mode)
      MODE_EXT: cur_depth = CW'(MAXD);
      MODE_STD: cur_depth = CW'(SMALLD);
      default:  cur_depth = CW'(1);
    endcase
  end

  assign full      = (cnt >= cur_depth);
  assign empty     = (cnt == '0);
  assign do_push   = in_valid && !full;
  assign do_pop    = out_ready && !empty;
  assign in_ready  = !full;
  assign out_valid = !empty;
  assign out_data  = empty ? last_q : mem[rd_ptr];
  assign level     = cnt;

  function automatic logic [AW-1:0] bump(logic [AW-1:0] p, logic [CW-1:0] d);
    return (p == AW'(d - 1'b1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push && !clr) mem[wr_ptr] <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      cnt     <= '0;
      last_q  <= '0;
      overrun <= 1'b0;
    end else if (clr) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      cnt     <= '0;
      overrun <= 1'b0;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr, cur_depth);
      if (do_pop) begin
        rd_ptr <= bump(rd_ptr, cur_depth);
        last_q <= mem[rd_ptr];
      end
      if (do_push && !do_pop)      cnt <= cnt + 1'b1;
      else if (do_pop && !do_push) cnt <= cnt - 1'b1;
      if (in_valid && full) overrun <= 1'b1;
    end
  end

  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mode) == mode |-> level <= cur_depth);

  // R10
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun && !clr |=> overrun);

  // R11
  empty_pop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid && out_ready && !in_valid && !clr |=> $stable(level) && $stable(out_data));

  // R12
  push_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !(out_ready && out_valid) && !clr |=> level == $past(level) + 1'b1);

endmodule

// File: rtl/fcr_ctrl.sv
module fcr_ctrl
  import uart_fifo_pkg::*;
#(
  parameter logic [2:0] ADDR_CTL  = 3'd2,
  parameter logic [2:0] ADDR_LINE = 3'd3,
  parameter int         DLAB_BIT  = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [2:0] reg_addr,
  input  logic [7:0] reg_wdata,
  input  logic       rx_hit,
  output logic [7:0] reg_rdata,
  output fifo_mode_e mode,
  output logic [1:0] trig_code,
  output logic       rx_clr,
  output logic       tx_clr
);
  localparam int EN_BIT   = 0;
  localparam int RXF_BIT  = 1;
  localparam int TXF_BIT  = 2;
  localparam int DEEP_BIT = 5;
  localparam int TRG_LSB  = 6;

  logic [7:0] line_q;
  logic       en_q, deep_q;
  logic       ctl_wr, nxt_en, nxt_deep, mode_chg;

  assign ctl_wr   = reg_wr && (reg_addr == ADDR_CTL) && !line_q[DLAB_BIT];
  assign nxt_en   = reg_wdata[EN_BIT];
  assign nxt_deep = reg_wdata[EN_BIT] && reg_wdata[DEEP_BIT];
  assign mode_chg = ctl_wr && ((nxt_en != en_q) || (nxt_deep != deep_q));
  assign rx_clr   = mode_chg || (ctl_wr && reg_wdata[RXF_BIT]);
  assign tx_clr   = mode_chg || (ctl_wr && reg_wdata[TXF_BIT]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q    <= '0;
      en_q      <= 1'b0;
      deep_q    <= 1'b0;
      trig_code <= '0;
    end else begin
      if (reg_wr && reg_addr == ADDR_LINE) line_q <= reg_wdata;
      if (ctl_wr) begin
        en_q      <= nxt_en;
        deep_q    <= nxt_deep;
        trig_code <= reg_wdata[TRG_LSB +: 2];
      end
    end
  end

  always_comb begin
    if (!en_q)       mode = MODE_OFF;
    else if (deep_q) mode = MODE_EXT;
    else             mode = MODE_STD;
  end

  always_comb begin
    case (reg_addr)
      ADDR_CTL:  reg_rdata = {en_q, en_q, en_q && deep_q, 1'b0,
                              rx_hit ? 4'b0100 : 4'b0001};
      ADDR_LINE: reg_rdata = line_q;
      default:   reg_rdata = '0;
    endcase
  end

  // R3
  deep_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode != MODE_EXT || reg_rdata[7:5] == 3'b111 || reg_addr != ADDR_CTL);

  // R2
  dlab_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_addr == ADDR_CTL && line_q[DLAB_BIT] |=> $stable(mode) && $stable(trig_code));

  // R9
  flush_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_clr |-> reg_wr);

endmodule

// File: rtl/rx_trigger.sv
module rx_trigger
  import uart_fifo_pkg::*;
#(
  parameter int LW = LVL_W
) (
  input  fifo_mode_e    mode,
  input  logic [1:0]    code,
  input  logic [LW-1:0] level,
  output logic          hit
);
  level_t thr;
  assign thr = trig_of(mode, code);
  assign hit = (level >= LW'(thr));

  // R7
  always_comb begin
    if (level == '0) hit_zero_chk: assert (!hit);
  end
endmodule

// File: rtl/uart_fifo_ctl.sv
module uart_fifo_ctl
  import uart_fifo_pkg::*;
#(
  parameter int DW     = DATA_W,
  parameter int MAXD   = MAX_DEPTH,
  parameter int SMALLD = SMALL_DEPTH
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      reg_wr,
  input  logic [2:0]                reg_addr,
  input  logic [7:0]                reg_wdata,
  output logic [7:0]                reg_rdata,
  input  logic                      rx_in_valid,
  output logic                      rx_in_ready,
  input  logic [DW-1:0]             rx_in_data,
  output logic                      rx_out_valid,
  input  logic                      rx_out_ready,
  output logic [DW-1:0]             rx_out_data,
  input  logic                      tx_in_valid,
  output logic                      tx_in_ready,
  input  logic [DW-1:0]             tx_in_data,
  output logic                      tx_out_valid,
  input  logic                      tx_out_ready,
  output logic [DW-1:0]             tx_out_data,
  output logic [$clog2(MAXD+1)-1:0] rx_level,
  output logic                      rx_data_avail,
  output logic                      rx_overrun,
  output logic                      tx_overrun
);
  localparam int CW = $clog2(MAXD + 1);

  fifo_mode_e    mode;
  logic [1:0]    trig_code;
  logic          rx_clr, tx_clr;
  logic [CW-1:0] tx_level;

  fcr_ctrl u_ctl (
    .clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata,
    .rx_hit(rx_data_avail), .reg_rdata, .mode, .trig_code, .rx_clr, .tx_clr
  );

  fifo_core #(.DW(DW), .MAXD(MAXD), .SMALLD(SMALLD)) u_rxq (
    .clk, .rst_n, .clr(rx_clr), .mode,
    .in_valid(rx_in_valid), .in_ready(rx_in_ready), .in_data(rx_in_data),
    .out_valid(rx_out_valid), .out_ready(rx_out_ready), .out_data(rx_out_data),
    .level(rx_level), .overrun(rx_overrun)
  );

  fifo_core #(.DW(DW), .MAXD(MAXD), .SMALLD(SMALLD)) u_txq (
    .clk, .rst_n, .clr(tx_clr), .mode,
    .in_valid(tx_in_valid), .in_ready(tx_in_ready), .in_data(tx_in_data),
    .out_valid(tx_out_valid), .out_ready(tx_out_ready), .out_data(tx_out_data),
    .level(tx_level), .overrun(tx_overrun)
  );

  rx_trigger #(.LW(CW)) u_trg (
    .mode, .code(trig_code), .level(rx_level), .hit(rx_data_avail)
  );

  // R8
  mode_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode != $past(mode) |-> rx_level == '0 && tx_level == '0);

endmodule

// File: tb/test_uart_fifo_ctl.sv
module test_uart_fifo_ctl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       rx_in_valid = 1'b0, rx_out_ready = 1'b0;
  logic       tx_in_valid = 1'b0, tx_out_ready = 1'b0;
  logic [7:0] rx_in_data = '0, tx_in_data = '0;
  logic       rx_in_ready, rx_out_valid, tx_in_ready, tx_out_valid;
  logic [7:0] rx_out_data, tx_out_data;
  logic [6:0] rx_level;
  logic       rx_data_avail, rx_overrun, tx_overrun;

  int         n_chk = 0, n_bad = 0;
  bit         done = 1'b0;
  logic [7:0] exp_q[$];
  logic [7:0] last_seen = '0;
  logic [7:0] seed = 8'h10;

  always #5 clk = ~clk;

  uart_fifo_ctl i_uart_fifo_ctl (.*);

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  // Monitor: compares every byte leaving the receive queue with the scoreboard.
  always @(posedge clk) begin
    if (rst_n && rx_out_valid && rx_out_ready) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R12: got %0h expected nothing", rx_out_data);
      end else begin
        if (rx_out_data != exp_q[0]) begin
          n_bad++;
          $display("FAIL R12: got %0h expected %0h", rx_out_data, exp_q[0]);
        end
        void'(exp_q.pop_front());
      end
      last_seen = rx_out_data;
    end
  end

  task automatic wr(logic [2:0] a, logic [7:0] d, bit flush_rx);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk); #1;
    reg_wr = 1'b0;
    if (flush_rx) exp_q.delete();
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] v);
    reg_addr = a; #1; v = reg_rdata;
  endtask

  // Driver: offers one byte; records it on the scoreboard if it is taken.
  task automatic push_rx(logic [7:0] d);
    bit acc;
    rx_in_valid = 1'b1; rx_in_data = d;
    #3; acc = rx_in_ready;
    if (acc) exp_q.push_back(d);
    @(posedge clk); #1;
    rx_in_valid = 1'b0;
  endtask

  task automatic push_n(int n);
    for (int i = 0; i < n; i++) begin
      push_rx(seed);
      seed = seed + 8'd7;
    end
  endtask

  task automatic pop_rx();
    rx_out_ready = 1'b1;
    @(posedge clk); #1;
    rx_out_ready = 1'b0;
  endtask

  task automatic trig_case(string tag, logic [7:0] base, logic [1:0] code, int thr);
    logic [7:0] v;
    wr(3'd2, {code, base[5:0]} | 8'h02, 1'b1);
    chk({tag, " flushed"}, rx_level, 0);
    push_n(thr - 1);
    chk({tag, " below"}, rx_data_avail, 0);
    push_n(1);
    chk({tag, " reached"}, rx_data_avail, 1);
    rd(3'd2, v);
    chk("R7 iir low", v[3:0], 4'b0100);
    pop_rx();
    chk("R7 drop", rx_data_avail, 0);
    rd(3'd2, v);
    chk("R7 iir idle", v[3:0], 4'b0001);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;

    // R1 reset state
    rd(3'd2, v);
    chk("R1 iir", v, 8'h01);
    chk("R1 ready", rx_in_ready, 1);
    chk("R1 empty", rx_out_valid, 0);
    chk("R1 ovr", rx_overrun, 0);

    // R4 disabled depth one, R10 overrun
    push_rx(8'hA5);
    chk("R4 depth1 full", rx_in_ready, 0);
    push_rx(8'h5A);
    chk("R10 ovr set", rx_overrun, 1);
    pop_rx();
    chk("R12 drained", rx_level, 0);

    // R2 write blocked while divisor access is set
    wr(3'd3, 8'h80, 1'b0);
    wr(3'd2, 8'h01, 1'b0);
    rd(3'd2, v);
    chk("R2 blocked", v, 8'h01);
    wr(3'd3, 8'h00, 1'b0);

    // R3 extended bit without enable
    wr(3'd2, 8'h20, 1'b0);
    rd(3'd2, v);
    chk("R3 deep alone", v, 8'h01);
    wr(3'd2, 8'h01, 1'b1);
    rd(3'd2, v);
    chk("R3 std iir", v, 8'hC1);
    chk("R10 ovr cleared", rx_overrun, 0);

    // R5 standard triggers
    trig_case("R5 c0", 8'h01, 2'd0, 1);
    trig_case("R5 c1", 8'h01, 2'd1, 4);
    trig_case("R5 c2", 8'h01, 2'd2, 8);
    trig_case("R5 c3", 8'h01, 2'd3, 14);

    // R4 standard depth, R10 sticky
    wr(3'd2, 8'h03, 1'b1);
    push_n(16);
    chk("R4 std full", rx_in_ready, 0);
    chk("R4 std level", rx_level, 16);
    push_n(1);
    chk("R10 std ovr", rx_overrun, 1);
    for (int i = 0; i < 16; i++) pop_rx();
    chk("R10 sticky", rx_overrun, 1);

    // R8 same mode keeps data
    push_n(3);
    wr(3'd2, 8'h01, 1'b0);
    chk("R8 same mode", rx_level, 3);
    chk("R9 self clear", rx_level, 3);
    wr(3'd2, 8'h21, 1'b1);
    rd(3'd2, v);
    chk("R3 ext iir", v, 8'hE1);
    chk("R8 mode flush", rx_level, 0);

    // R6 extended triggers
    trig_case("R6 c0", 8'h21, 2'd0, 1);
    trig_case("R6 c1", 8'h21, 2'd1, 16);
    trig_case("R6 c2", 8'h21, 2'd2, 32);
    trig_case("R6 c3", 8'h21, 2'd3, 56);

    // R4 extended depth with wrap
    wr(3'd2, 8'h23, 1'b1);
    push_n(64);
    chk("R4 ext level", rx_level, 64);
    chk("R4 ext full", rx_in_ready, 0);
    push_n(1);
    chk("R10 ext ovr", rx_overrun, 1);

    // R9 transmit flush only
    tx_in_valid = 1'b1; tx_in_data = 8'h3C;
    repeat (3) @(posedge clk);
    #1 tx_in_valid = 1'b0;
    chk("R9 tx filled", tx_out_valid, 1);
    chk("R9 tx data", tx_out_data, 8'h3C);
    wr(3'd2, 8'h25, 1'b0);
    chk("R9 tx flushed", tx_out_valid, 0);
    chk("R9 rx kept", rx_level, 64);
    wr(3'd2, 8'h23, 1'b1);
    chk("R9 rx flushed", rx_level, 0);

    // R12 simultaneous enter and leave
    push_n(2);
    rx_in_valid = 1'b1; rx_in_data = 8'hC7; rx_out_ready = 1'b1;
    #3 exp_q.push_back(8'hC7);
    @(posedge clk); #1;
    rx_in_valid = 1'b0; rx_out_ready = 1'b0;
    chk("R12 level steady", rx_level, 2);
    pop_rx();
    pop_rx();
    chk("R12 queue done", exp_q.size(), 0);

    // R11 read from empty
    pop_rx();
    chk("R11 level", rx_level, 0);
    chk("R11 data", rx_out_data, last_seen);

    // R3 disable
    wr(3'd2, 8'h00, 1'b1);
    rd(3'd2, v);
    chk("R3 off iir", v, 8'h01);

    repeat (2) @(posedge clk);
    finish_run();
  end
endmodule